// File: doc/BRIEF.md
# Character-Synchronous Serial Transmitter with Sync Fill

This block turns parallel characters into a bit stream for a character-synchronous serial link. The CPU side writes data characters into a one-deep holding buffer. When the shift register is free, that buffer is moved into the shift register. Each pulse on the bit clock enable moves one bit onto the serial line. There are no start or stop bits.

The line never goes quiet while the transmitter is enabled. If no data character is waiting when the current character finishes, the block sends a programmed sync character instead. In double-sync mode it sends two different sync characters as an unbroken pair. Character length (5 to 8 bits) and parity (off, even or odd) are set at run time through a small configuration port. The same framing applies to data and sync characters.

The configuration port selects a register with `cfg_addr`:
- 0: mode.
- 1: first sync character.
- 2: second sync character.

The mode byte has these fields:
- bits [1:0]: length minus 5.
- bit 2: parity enable.
- bit 3: odd parity when 1, even when 0.
- bit 4: double sync.
- bit 5: transmitter enable.

Top module: `sync_char_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1. All configuration registers are zero, so the transmitter starts disabled.
- R2: While mode bit 5 is 0, `txd` stays at 1 and bit enable pulses have no effect. Writing the mode with bit 5 at 0 abandons the character in flight and any pending second sync character.
- R3: While enabled, each `bit_ce` pulse puts exactly one new bit on `txd`, least significant bit first. `txd` does not change in cycles without `bit_ce`.
- R4: The character length is 5 + mode[1:0] bits. Data bits above that length are ignored.
- R5: When mode bit 2 is 1, a parity bit follows the data bits. It makes the count of ones even when mode bit 3 is 0, and odd when mode bit 3 is 1.
- R6: When a character ends and the holding buffer is empty, the next character sent is the first sync character.
- R7: With mode bit 4 set, the first sync character is always followed by the second sync character. This holds even if data arrives during the first one; the data character is sent after the pair.
- R8: A data write while `tx_ready` is 1 fills the holding buffer and drops `tx_ready`. `tx_ready` returns to 1 in the cycle the buffer moves into the shift register.
- R9: A data write while `tx_ready` is 0 is ignored, and its character is never sent.
- R10: `tx_empty` is 1 only when the holding buffer is empty and no data character is being shifted out. Sync characters being sent do not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 first sync, 2 second sync |
| cfg_wdata | input | 8 | Configuration write data |
| dat_we | input | 1 | Data character write strobe |
| dat_wdata | input | 8 | Data character |
| bit_ce | input | 1 | Transmit bit clock enable, one bit per pulse |
| txd | output | 1 | Serial data output |
| tx_ready | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | No data character held or being shifted |

## Verification
The hardest case to reach is a data character that arrives in the middle of the first character of a sync pair. The pair must still finish before the data goes out. The bench reaches it directly: it enables double-sync mode with no data, sends one bit of the first sync character, and only then writes the data. It then checks the whole sequence: the rest of the first sync, the second sync, and then the data.

Random trials restart the framing in each run by disabling the transmitter. Each trial picks length, parity, sync count and the gaps between bit pulses at random. Every trial also tries a write into a full buffer.

// File: rtl/sctx_pkg.sv
`timescale 1ns/1ps
package sctx_pkg;
  typedef enum logic [1:0] {
    SRC_SYNC1 = 2'd0,
    SRC_SYNC2 = 2'd1,
    SRC_DATA  = 2'd2
  } src_e;

  typedef struct packed {
    logic       en;
    logic       dbl;
    logic       odd;
    logic       pe;
    logic [1:0] len;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/sctx_cfg.sv
`timescale 1ns/1ps
module sctx_cfg
  import sctx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CHAR_W-1:0] wdata,
  output mode_t             mode,
  output logic [CHAR_W-1:0] sync1,
  output logic [CHAR_W-1:0] sync2
);
  mode_t             mode_q, mode_d;
  logic [CHAR_W-1:0] s1_q, s1_d, s2_q, s2_d;

  always_comb begin
    mode_d = mode_q;
    s1_d   = s1_q;
    s2_d   = s2_q;
    if (we) begin
      unique case (addr)
        2'd0:    mode_d = mode_t'(wdata[MODE_W-1:0]);
        2'd1:    s1_d   = wdata;
        2'd2:    s2_d   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
    end else begin
      mode_q <= mode_d;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
    end
  end

  assign mode  = mode_q;
  assign sync1 = s1_q;
  assign sync2 = s2_q;
endmodule

// File: rtl/sctx_hold.sv
`timescale 1ns/1ps
module sctx_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              drain,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  logic              full_q, full_d;
  logic [CHAR_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (drain) full_d = 1'b0;
    if (we && !full_q) begin
      full_d = 1'b1;
      data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && we) |=> $stable(data_q));
endmodule

// File: rtl/sctx_seq.sv
`timescale 1ns/1ps
module sctx_seq
  import sctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dbl,
  input  logic hold_full,
  input  logic load,
  output src_e src
);
  logic pend_q, pend_d;

  always_comb begin
    if (pend_q)         src = SRC_SYNC2;
    else if (hold_full) src = SRC_DATA;
    else                src = SRC_SYNC1;
  end

  always_comb begin
    pend_d = pend_q;
    if (!en)       pend_d = 1'b0;
    else if (load) pend_d = (src == SRC_SYNC1) && dbl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assert_pair_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && en && dbl && src == SRC_SYNC1) |=> (src == SRC_SYNC2));
endmodule

// File: rtl/sctx_shift.sv
`timescale 1ns/1ps
module sctx_shift #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pe,
  input  logic              odd,
  input  logic [1:0]        len_sel,
  input  logic              bit_ce,
  input  logic [CHAR_W-1:0] chr,
  input  logic              is_data,
  output logic              load,
  output logic              txd,
  output logic              data_busy
);
  localparam int unsigned FRM_W   = CHAR_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRM_W + 1);
  localparam int unsigned MIN_LEN = CHAR_W - 3;

  logic [FRM_W-1:0]  sh_q, sh_d, frame;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len, nbits;
  logic              txd_q, txd_d, dat_q, dat_d;
  logic [CHAR_W-1:0] masked;
  logic              par;

  always_comb begin
    len = CNT_W'(MIN_LEN) + CNT_W'(len_sel);
    for (int i = 0; i < CHAR_W; i++) begin
      masked[i] = chr[i] & (CNT_W'(i) < len);
    end
    par   = (^masked) ^ odd;
    frame = {1'b0, masked};
    if (pe) frame[len] = par;
    nbits = len + CNT_W'(pe);
  end

  assign load = en && bit_ce && (cnt_q == '0);

  always_comb begin
    txd_d = txd_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    dat_d = dat_q;
    if (!en) begin
      txd_d = 1'b1;
      sh_d  = '0;
      cnt_d = '0;
      dat_d = 1'b0;
    end else if (load) begin
      txd_d = frame[0];
      sh_d  = frame >> 1;
      cnt_d = nbits - CNT_W'(1);
      dat_d = is_data;
    end else if (bit_ce) begin
      txd_d = sh_q[0];
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
      dat_q <= 1'b0;
    end else begin
      txd_q <= txd_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      dat_q <= dat_d;
    end
  end

  assign txd       = txd_q;
  assign data_busy = dat_q && (cnt_q != '0);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd_q);
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_ce) |=> $stable(txd_q));
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(FRM_W));
endmodule

// File: rtl/sync_char_tx.sv
`timescale 1ns/1ps
module sync_char_tx
  import sctx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic              dat_we,
  input  logic [CHAR_W-1:0] dat_wdata,
  input  logic              bit_ce,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  mode_t             mode;
  logic [CHAR_W-1:0] sync1, sync2, hold_data, chr;
  logic              hold_full, load, drain, data_busy;
  src_e              src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  sctx_cfg #(.CHAR_W(CHAR_W)) u_cfg (
    .clk(clk), .rst_n(rst_i), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .sync1(sync1), .sync2(sync2)
  );

  assign drain = load && (src == SRC_DATA);

  sctx_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk(clk), .rst_n(rst_i), .we(dat_we), .wdata(dat_wdata), .drain(drain),
    .full(hold_full), .data(hold_data)
  );

  sctx_seq u_seq (
    .clk(clk), .rst_n(rst_i), .en(mode.en), .dbl(mode.dbl),
    .hold_full(hold_full), .load(load), .src(src)
  );

  always_comb begin
    unique case (src)
      SRC_DATA:  chr = hold_data;
      SRC_SYNC2: chr = sync2;
      default:   chr = sync1;
    endcase
  end

  sctx_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .en(mode.en), .pe(mode.pe), .odd(mode.odd),
    .len_sel(mode.len), .bit_ce(bit_ce), .chr(chr), .is_data(src == SRC_DATA),
    .load(load), .txd(txd), .data_busy(data_busy)
  );

  assign tx_ready = !hold_full;
  assign tx_empty = !hold_full && !data_busy;

  assert_ready_on_transfer_R8: assert property (@(posedge clk) disable iff (!rst_i)
    drain |=> tx_ready);
endmodule

// File: tb/sync_char_tx_test.sv
`timescale 1ns/1ps
module sync_char_tx_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, dat_we, bit_ce;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata, dat_wdata;
  logic       txd, tx_ready, tx_empty;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sync_char_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .bit_ce(bit_ce), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] frame_of(logic [7:0] ch, int len, bit pe, bit odd);
    logic [8:0] f = '0;
    int ones = 0;
    for (int i = 0; i < len; i++) begin
      f[i] = ch[i];
      ones += int'(ch[i]);
    end
    if (pe) f[len] = ((ones % 2) != 0) ^ odd;
    return f;
  endfunction

  function automatic logic [7:0] mode_b(int len, bit pe, bit odd, bit dbl, bit en);
    logic [1:0] l = 2'(len - 5);
    return {2'b00, en, dbl, odd, pe, l};
  endfunction

  task automatic wr_cfg(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] d);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic pulse(output logic b);
    int   gap = $urandom_range(0, 2);
    logic held = txd;
    for (int g = 0; g < gap; g++) @(negedge clk);
    if (gap > 0) chk("R3", "txd without bit_ce", int'(txd), int'(held));
    bit_ce = 1'b1;
    @(negedge clk);
    bit_ce = 1'b0;
    b = txd;
  endtask

  task automatic get_frame(int n, output logic [8:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      pulse(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    logic       b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; dat_we = 0; bit_ce = 0;
    cfg_addr = 0; cfg_wdata = 0; dat_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1", "txd after reset", int'(txd), 1);
    chk("R1", "tx_ready after reset", int'(tx_ready), 1);
    chk("R1", "tx_empty after reset", int'(tx_empty), 1);

    for (int i = 0; i < 3; i++) begin
      pulse(b);
      chk("R2", "txd while disabled", int'(b), 1);
    end

    // single sync: data then underrun fill
    wr_cfg(2'd1, 8'h16);
    wr_cfg(2'd0, mode_b(8, 0, 0, 0, 0));
    wr_dat(8'hA5);
    wr_cfg(2'd0, mode_b(8, 0, 0, 0, 1));
    get_frame(8, v);
    chk("R3", "first data frame", int'(v), int'(frame_of(8'hA5, 8, 0, 0)));
    chk("R10", "tx_empty after data done", int'(tx_empty), 1);
    get_frame(8, v);
    chk("R6", "sync after underrun", int'(v), int'(frame_of(8'h16, 8, 0, 0)));
    chk("R10", "tx_empty during sync fill", int'(tx_empty), 1);

    // double sync: data arrives inside first sync
    wr_cfg(2'd0, mode_b(8, 0, 0, 1, 0));
    wr_cfg(2'd1, 8'h32);
    wr_cfg(2'd2, 8'h4C);
    wr_cfg(2'd0, mode_b(8, 0, 0, 1, 1));
    pulse(b);
    v = '0;
    v[0] = b;
    wr_dat(8'h5A);
    chk("R10", "tx_empty with held data", int'(tx_empty), 0);
    chk("R8", "tx_ready with held data", int'(tx_ready), 0);
    for (int i = 1; i < 8; i++) begin
      pulse(b);
      v[i] = b;
    end
    chk("R7", "first sync of pair", int'(v), int'(frame_of(8'h32, 8, 0, 0)));
    get_frame(8, v);
    chk("R7", "second sync before data", int'(v), int'(frame_of(8'h4C, 8, 0, 0)));
    get_frame(8, v);
    chk("R7", "data after pair", int'(v), int'(frame_of(8'h5A, 8, 0, 0)));
    get_frame(3, v);
    wr_cfg(2'd0, mode_b(8, 0, 0, 1, 0));
    @(negedge clk);
    chk("R2", "txd after disable mid-char", int'(txd), 1);
    pulse(b);
    chk("R2", "bit_ce ignored when disabled", int'(b), 1);

    // random trials
    for (int t = 0; t < 40; t++) begin
      int         len = 5 + int'($urandom_range(0, 3));
      bit         pe  = 1'($urandom_range(0, 1));
      bit         odd = 1'($urandom_range(0, 1));
      bit         dbl = 1'($urandom_range(0, 1));
      logic [7:0] s1  = 8'($urandom);
      logic [7:0] s2  = 8'($urandom);
      logic [7:0] d1  = 8'($urandom);
      logic [7:0] d2  = ~d1;
      int         n   = len + int'(pe);
      wr_cfg(2'd0, mode_b(len, pe, odd, dbl, 0));
      wr_cfg(2'd1, s1);
      wr_cfg(2'd2, s2);
      wr_dat(d1);
      chk("R8", "tx_ready after write", int'(tx_ready), 0);
      wr_dat(d2);
      wr_cfg(2'd0, mode_b(len, pe, odd, dbl, 1));
      get_frame(n, v);
      chk("R5", "data frame length/parity (R4)", int'(v), int'(frame_of(d1, len, pe, odd)));
      chk("R8", "tx_ready after transfer", int'(tx_ready), 1);
      chk("R10", "tx_empty after data", int'(tx_empty), 1);
      get_frame(n, v);
      chk("R9", "sync follows, dropped write unsent (R6)", int'(v),
          int'(frame_of(s1, len, pe, odd)));
      get_frame(n, v);
      if (dbl) chk("R7", "second sync in random", int'(v), int'(frame_of(s2, len, pe, odd)));
      else     chk("R6", "repeat sync in random", int'(v), int'(frame_of(s1, len, pe, odd)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule